// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software sets it up through a 32-bit, word-addressed register port. It writes a divide setting, a timer entry that carries a vector, a mask bit and a mode bit, and then an initial count. The count then runs down at the bus clock divided by the programmed ratio. When the count expires, the block emits a one-cycle interrupt request that carries the programmed vector, unless the entry is masked.

In one-shot mode the timer stops once it has expired. In periodic mode it reloads from the initial count and carries on. Software can read the running count at any time, and it can also overwrite it. The register port is plain control: a write strobe with an address and data, and a read-data output that follows the address combinationally. The port has no handshake and no back-pressure, because every access completes in the cycle it is presented.

Top module: `lcl_timer`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), and the initial count, current count and divide registers read 0. No interrupt is pending.
- R2: Word indices: 0xC8 is the timer entry, 0xE0 the initial count, 0xE4 the current count and 0xF8 the divide register. The timer entry keeps bits 17, 16 and 7:0, and the divide register keeps bits 3, 1 and 0; all other bits read 0. Any other index reads 0, and writes to it change nothing.
- R3: A write to the initial count stores the value and loads it into the current count. A non-zero value starts counting and a zero value stops the timer.
- R4: The divide code {bit3,bit1,bit0} gives the ratio: 000=/2, 001=/4, 010=/8, 011=/16, 100=/32, 101=/64, 110=/128, 111=/1 (so 0xB is /1). A running count decrements once every ratio cycles.
- R5: A write to the initial count, current count or divide register restarts the divider phase. The next decrement then falls exactly ratio cycles after that write.
- R6: In one-shot mode (entry bit 17 = 0), the decrement from 1 leaves the count at 0. The timer then stays stopped and produces exactly one interrupt.
- R7: In periodic mode (entry bit 17 = 1), the decrement that would reach 0 reloads the initial count instead. This gives one expiry every initial-count × ratio cycles.
- R8: With entry bit 16 set, an expiry produces no interrupt pulse, but counting and reloading continue unchanged.
- R9: `irq_pulse` is high for one cycle, in the cycle after the decrement from 1. `irq_vector` then shows entry bits 7:0 as they were at that decrement, and it holds that value until the next pulse.
- R10: A write to the current count replaces the count, even in a cycle where a decrement is due. A non-zero value keeps or starts counting and a zero value stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest delivered interrupt |

## Verification
A wrong count shows up on the current-count readback in the very cycle after the faulty edge, because the bench keeps that register addressed whenever it is not writing. A wrong divider phase or a wrong reload also surfaces there first. The interrupt pulse then arrives a whole number of divided periods early or late. A corrupted mask or mode bit stays hidden until the next expiry, and it then appears as a missing or extra pulse or as a count that fails to reload, within one initial-count period.

// File: rtl/lcl_timer_pkg.sv
package lcl_timer_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int VEC_W     = 8;
  localparam int PRESC_W   = 7;

  localparam int IDX_ENTRY = 'h320 / 4;
  localparam int IDX_INIT  = 'h380 / 4;
  localparam int IDX_CUR   = 'h390 / 4;
  localparam int IDX_DIV   = 'h3E0 / 4;

  localparam int BIT_MASK  = 16;
  localparam int BIT_PER   = 17;

  // Divide code {b3,b1,b0}: 7 means /1, otherwise /2^(code+1).
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    if (code == 3'b111) return 3'd0;
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lcl_timer_regs.sv
module lcl_timer_regs
  import lcl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_entry,
  input  logic              we_init,
  input  logic              we_div,
  input  logic [DATA_W-1:0] wdata,
  output logic [VEC_W-1:0]  ent_vec,
  output logic              ent_mask,
  output logic              ent_per,
  output logic [DATA_W-1:0] init_cnt,
  output logic [2:0]        div_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vec  <= '0;
      ent_mask <= 1'b1;
      ent_per  <= 1'b0;
      init_cnt <= '0;
      div_code <= '0;
    end else begin
      if (we_entry) begin
        ent_vec  <= wdata[VEC_W-1:0];
        ent_mask <= wdata[BIT_MASK];
        ent_per  <= wdata[BIT_PER];
      end
      if (we_init) init_cnt <= wdata;
      if (we_div)  div_code <= {wdata[3], wdata[1], wdata[0]};
    end
  end
endmodule

// File: rtl/lcl_timer_presc.sv
module lcl_timer_presc
  import lcl_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] div_code,
  output logic       tick
);
  logic [PRESC_W-1:0] phase;
  logic [PRESC_W-1:0] span;

  always_comb begin
    span = (PRESC_W'(1) << div_shift(div_code)) - PRESC_W'(1);
    tick = (phase & span) == span;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else              phase <= phase + PRESC_W'(1);
  end
endmodule

// File: rtl/lcl_timer_count.sv
module lcl_timer_count
  import lcl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] init_cnt,
  input  logic              periodic,
  input  logic              tick,
  output logic [DATA_W-1:0] cur_cnt,
  output logic              active,
  output logic              fire
);
  logic last;
  assign last = cur_cnt == DATA_W'(1);
  assign fire = active && tick && last && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt <= '0;
      active  <= 1'b0;
    end else if (load) begin
      cur_cnt <= load_val;
      active  <= |load_val;
    end else if (active && tick) begin
      if (!last) begin
        cur_cnt <= cur_cnt - DATA_W'(1);
      end else if (periodic) begin
        cur_cnt <= init_cnt;
        active  <= |init_cnt;
      end else begin
        cur_cnt <= '0;
        active  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcl_timer.sv
module lcl_timer
  import lcl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  logic we_entry, we_init, we_cur, we_div;
  logic [VEC_W-1:0]  ent_vec;
  logic              ent_mask, ent_per;
  logic [DATA_W-1:0] init_cnt, cur_cnt;
  logic [2:0]        div_code;
  logic              tick, active, fire;

  assign we_entry = reg_we && (reg_addr == ADDR_W'(IDX_ENTRY));
  assign we_init  = reg_we && (reg_addr == ADDR_W'(IDX_INIT));
  assign we_cur   = reg_we && (reg_addr == ADDR_W'(IDX_CUR));
  assign we_div   = reg_we && (reg_addr == ADDR_W'(IDX_DIV));

  lcl_timer_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_entry(we_entry), .we_init(we_init), .we_div(we_div),
    .wdata(reg_wdata),
    .ent_vec(ent_vec), .ent_mask(ent_mask), .ent_per(ent_per),
    .init_cnt(init_cnt), .div_code(div_code)
  );

  lcl_timer_presc u_presc (
    .clk(clk), .rst_n(rst_n),
    .restart(we_init | we_cur | we_div),
    .div_code(div_code), .tick(tick)
  );

  lcl_timer_count u_count (
    .clk(clk), .rst_n(rst_n),
    .load(we_init | we_cur), .load_val(reg_wdata),
    .init_cnt(init_cnt), .periodic(ent_per), .tick(tick),
    .cur_cnt(cur_cnt), .active(active), .fire(fire)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(IDX_ENTRY): begin
        reg_rdata[VEC_W-1:0] = ent_vec;
        reg_rdata[BIT_MASK]  = ent_mask;
        reg_rdata[BIT_PER]   = ent_per;
      end
      ADDR_W'(IDX_INIT): reg_rdata = init_cnt;
      ADDR_W'(IDX_CUR):  reg_rdata = cur_cnt;
      ADDR_W'(IDX_DIV): begin
        reg_rdata[3] = div_code[2];
        reg_rdata[1] = div_code[1];
        reg_rdata[0] = div_code[0];
      end
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= fire && !ent_mask;
      if (fire && !ent_mask) irq_vector <= ent_vec;
    end
  end
endmodule

// File: rtl/lcl_timer_chk.sv
module lcl_timer_chk
  import lcl_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              irq_pulse,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [DATA_W-1:0] cur_cnt,
  input logic [DATA_W-1:0] init_cnt,
  input logic              active,
  input logic              tick,
  input logic              fire,
  input logic              ent_mask,
  input logic              ent_per
);
  AST_ZERO_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt == '0) |-> !active); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && cur_cnt != DATA_W'(1) && !reg_we) |=> (cur_cnt == $past(cur_cnt) - DATA_W'(1))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !reg_we) |=> $stable(cur_cnt)); // R6

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ent_per) |=> (cur_cnt == $past(init_cnt))); // R7

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(ent_mask)); // R8

  AST_IRQ_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(cur_cnt) == DATA_W'(1) && $past(tick))); // R9

  AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> $stable(irq_vector)); // R9
endmodule

bind lcl_timer lcl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .irq_pulse(irq_pulse), .irq_vector(irq_vector),
  .cur_cnt(cur_cnt), .init_cnt(init_cnt), .active(active),
  .tick(tick), .fire(fire), .ent_mask(ent_mask), .ent_per(ent_per)
);

// File: tb/tb_lcl_timer.sv
module tb_lcl_timer;
  localparam logic [7:0] A_ENT  = 8'hC8;
  localparam logic [7:0] A_INIT = 8'hE0;
  localparam logic [7:0] A_CUR  = 8'hE4;
  localparam logic [7:0] A_DIV  = 8'hF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'hE4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  lcl_timer dut (.*);

  always #2 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    chk_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [7:0]  m_vec;
  logic        m_mask, m_per, m_act, m_irq;
  logic [31:0] m_init, m_cur;
  logic [3:0]  m_div;
  logic [7:0]  m_ivec;
  int          m_phase;

  function automatic int ratio(input logic [3:0] d);
    int code;
    code = {d[3], d[1], d[0]};
    return (code == 7) ? 1 : (2 << code);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      A_ENT:   return {14'd0, m_per, m_mask, 8'd0, m_vec};
      A_INIT:  return m_init;
      A_CUR:   return m_cur;
      A_DIV:   return {28'd0, m_div & 4'hB};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vec = 0; m_mask = 1; m_per = 0; m_act = 0; m_irq = 0;
      m_init = 0; m_cur = 0; m_div = 0; m_ivec = 0; m_phase = 0;
    end else begin
      bit tk, ld, fired;
      int n;
      n = ratio(m_div);
      tk = (m_phase % n) == n - 1;
      ld = reg_we && (reg_addr == A_INIT || reg_addr == A_CUR);
      fired = 0;
      if (ld) begin
        m_cur = reg_wdata; m_act = reg_wdata != 0;
      end else if (m_act && tk) begin
        if (m_cur == 1) begin
          fired = 1;
          if (m_per) begin m_cur = m_init; m_act = m_init != 0; end
          else begin m_cur = 0; m_act = 0; end
        end else m_cur = m_cur - 1;
      end
      m_irq = fired && !m_mask;
      if (m_irq) m_ivec = m_vec;
      if (reg_we && reg_addr == A_INIT) m_init = reg_wdata;
      if (reg_we && reg_addr == A_DIV) m_div = reg_wdata[3:0];
      if (reg_we && reg_addr == A_ENT) begin
        m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16]; m_per = reg_wdata[17];
      end
      if (reg_we && (reg_addr == A_INIT || reg_addr == A_CUR || reg_addr == A_DIV))
        m_phase = 0;
      else m_phase = (m_phase + 1) % 128;
    end
  end

  task automatic check32(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (chk_on && !done) begin
      check32("irq_pulse", {31'd0, irq_pulse}, {31'd0, m_irq});
      check32("irq_vector", {24'd0, irq_vector}, {24'd0, m_ivec});
      check32("reg_rdata", reg_rdata, model_read(reg_addr));
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0; reg_addr = A_CUR; reg_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a;
    cyc();
    reg_addr = A_CUR;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  initial begin
    repeat (2) cyc();
    rst_n = 1'b1;
    chk_on = 1'b1;

    cur_req = "R1";
    rd(A_ENT); rd(A_INIT); rd(A_CUR); rd(A_DIV); idle(3);

    cur_req = "R2";
    wr(A_ENT, 32'hFFFF_FFFF); rd(A_ENT);
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV);
    wr(8'h40, 32'h1234_5678); rd(8'h40); rd(A_ENT); rd(A_INIT); rd(A_CUR);
    wr(A_ENT, 32'h0001_0000);

    cur_req = "R3";
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0000_0040);
    wr(A_INIT, 32'd5); idle(10);
    wr(A_INIT, 32'd20); idle(4);
    wr(A_INIT, 32'd0); idle(6); rd(A_INIT);

    cur_req = "R4";
    for (int c = 0; c < 8; c++) begin
      logic [3:0] d;
      d = {c[2], 1'b0, c[1], c[0]};
      wr(A_DIV, {28'd0, d});
      wr(A_INIT, 32'd3);
      idle(3 * ratio(d) + 4);
    end

    cur_req = "R5";
    wr(A_DIV, 32'h1);
    wr(A_INIT, 32'd6); idle(5);
    wr(A_DIV, 32'h2); idle(3);
    wr(A_DIV, 32'h0); idle(14);

    cur_req = "R6";
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h0000_0077);
    wr(A_INIT, 32'd2); idle(12);

    cur_req = "R7";
    wr(A_DIV, 32'h0);
    wr(A_ENT, 32'h0002_0033);
    wr(A_INIT, 32'd4); idle(30);
    wr(A_DIV, 32'hB);
    wr(A_INIT, 32'd1); idle(6);
    wr(A_ENT, 32'h0002_0055); idle(4);

    cur_req = "R8";
    wr(A_ENT, 32'h0003_0099);
    wr(A_INIT, 32'd3); idle(12);
    wr(A_ENT, 32'h0002_0011); idle(8);

    cur_req = "R9";
    wr(A_ENT, 32'h0000_00A5);
    wr(A_INIT, 32'd2); idle(3);
    wr(A_ENT, 32'h0000_005A); idle(6);

    cur_req = "R10";
    wr(A_ENT, 32'h0002_0021);
    wr(A_INIT, 32'd5); idle(2);
    wr(A_CUR, 32'd9); idle(3);
    wr(A_CUR, 32'd1);
    wr(A_CUR, 32'd7); idle(4);
    wr(A_CUR, 32'd0); idle(6);
    wr(A_ENT, 32'h0000_0021);
    wr(A_CUR, 32'd2); idle(5);

    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule